// File: doc/BRIEF.md
# Capture-Compare Timer Channel

A single 16-bit timer channel with an up-counter and four general registers (A, B, C, D). Each register is set on its own to be either a compare register, which changes a per-register output pin when the counter reaches it, or a capture register, which latches the counter when a chosen edge arrives on its input pin. The counter advances on a tick taken from one of eight power-of-two dividers of the system clock. It can be cleared by the event of any one chosen register.

Registers C and D can be paired with A and B as buffers. In capture mode, a capture into A or B first moves the old value into C or D. In compare mode, A or B is reloaded from C or D when a compare match clears the counter. A PWM mode routes the events of each pair to one pin, so that the two compare values set the rising and falling points of a waveform of any duty.

Software reaches the channel through a 16-bit write port and a combinational read port. There are five sticky event flags: one for each register's compare/capture event and one for counter overflow. Each flag is gated to an interrupt line by its own enable bit.

Top module: `cctimer`

## Requirements
- R1: After reset the counter, the control, mode, enable and flag registers read 0, the four general registers read 0xFFFF, and cmp_out and irq are 0.
- R2: Address 0 is the control register: bits 2:0 select the divider k, bit 6 runs the counter, bit 7 is PWM mode, bit 8 pairs C with A, and bit 9 pairs D with B. While running, the counter advances once every 2^k clocks, and the first advance comes 2^k clocks after the run bit is set. While stopped, the counter holds.
- R3: Address 1 holds 3 mode bits per register (A at bits 2:0, B at 5:3, C at 8:6, D at 11:9). With bit 2 of a field clear, the register compares, and on a match (counter equals the register on a tick) bits 1:0 act on that register's pin: 01 drives it to 0, 10 drives it to 1, 11 toggles it, and 00 leaves it unchanged.
- R4: With bit 2 of a field set, the register captures the counter on its cap_in pin after a two-flop synchronizer. Bits 1:0 of the field enable rising-edge capture (01), falling-edge capture (10) or capture on both edges (11). An edge that is not enabled leaves the register unchanged.
- R5: Control bits 5:3 choose the clear source: 0 is none, and 1 to 4 select the event of A to D. The selected event (compare match or capture) clears the counter to 0.
- R6: A tick at count 0xFFFF that does not clear the counter sets flag bit 4 (overflow).
- R7: Address 3 holds the flags: bits 3:0 are the events of A to D, and bit 4 is overflow. Flags are sticky. A write to address 3 keeps only the bits written as 1, and a new event wins over a clear in the same cycle. Address 2 holds the enables, and irq[i] is flag i AND enable i.
- R8: With A paired with C and A in capture mode, a capture loads the old A into C and the counter into A in the same clock. The same holds for B and D.
- R9: With A paired with C and A in compare mode, a compare match that clears the counter reloads A from C. The same holds for B and D.
- R10: In PWM mode the compare actions of A and B both act on cmp_out[0], and those of C and D act on cmp_out[2]. cmp_out[1] and cmp_out[3] read 0.
- R11: Address 4 is the counter and addresses 5 to 8 are registers A to D. A bus write to one of them takes priority over hardware updates, and the written value reads back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | Register address for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| cap_in | input | 4 | Capture pins for registers A to D (asynchronous) |
| cmp_out | output | 4 | Compare output pins for registers A to D |
| irq | output | 5 | Enabled flags: events of A to D, then overflow |

## Verification
The assertions assume that the cap_in pins are slow next to the clock. Each level must be held for several cycles so that the synchronizer sees every edge. They also assume that bus writes to the counter or to a general register are the only thing competing with hardware updates, and those cycles are excluded from the checks. The stimulus holds each capture level for five clocks and changes modes only while the counter is stopped. It stops the counter before every read, so that each expected value is a fixed number of ticks from the write that set the run bit.

// File: rtl/cctimer.sv
module cctimer #(
  parameter int W  = 16,
  parameter int PW = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic [3:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [3:0]   cap_in,
  output logic [3:0]   cmp_out,
  output logic [4:0]   irq
);
  localparam logic [3:0] A_CTRL = 4'd0, A_MODE = 4'd1, A_IEN = 4'd2,
                         A_FLAG = 4'd3, A_CNT  = 4'd4, A_GR   = 4'd5;

  logic [9:0]   ctrl;
  logic [11:0]  mode;
  logic [4:0]   ien, flags;
  logic [W-1:0] cnt;
  logic [W-1:0] gr [4];
  logic [PW-1:0] pre;
  logic [3:0]   s1, s2, s3, pin, pin_n;

  wire       run  = ctrl[6];
  wire       pwm  = ctrl[7];
  wire [1:0] bufen = ctrl[9:8];
  wire [2:0] clrsel = ctrl[5:3];
  wire [1:0] ci = clrsel[1:0] - 2'd1;
  wire       clr_on = (clrsel >= 3'd1) && (clrsel <= 3'd4);

  wire [PW-1:0] mask = (PW'(1) << ctrl[2:0]) - PW'(1);
  wire tick = run && ((pre & mask) == mask);

  wire [3:0] rise = s2 & ~s3;
  wire [3:0] fall = ~s2 & s3;

  logic [3:0] is_cap, capev, cmpev;
  always_comb begin
    for (int n = 0; n < 4; n++) begin
      is_cap[n] = mode[3*n+2];
      capev[n]  = is_cap[n] && ((mode[3*n] && rise[n]) || (mode[3*n+1] && fall[n]));
      cmpev[n]  = !is_cap[n] && tick && (cnt == gr[n]);
    end
  end

  wire [3:0] ev      = capev | cmpev;
  wire       clr     = clr_on && ev[ci];
  wire       cmp_clr = clr_on && cmpev[ci];
  wire       ovf     = tick && !clr && (cnt == '1);

  wire wr_cnt  = bus_wr && bus_addr == A_CNT;
  wire wr_flag = bus_wr && bus_addr == A_FLAG;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; mode <= '0; ien <= '0; flags <= '0;
      cnt <= '0; pre <= '0; s1 <= '0; s2 <= '0; s3 <= '0; pin <= '0;
    end else begin
      if (bus_wr && bus_addr == A_CTRL) ctrl <= bus_wdata[9:0];
      if (bus_wr && bus_addr == A_MODE) mode <= bus_wdata[11:0];
      if (bus_wr && bus_addr == A_IEN)  ien  <= bus_wdata[4:0];
      flags <= (wr_flag ? (flags & bus_wdata[4:0]) : flags) | {ovf, ev};
      if (wr_cnt)    cnt <= bus_wdata;
      else if (clr)  cnt <= '0;
      else if (tick) cnt <= cnt + W'(1);
      pre <= run ? pre + PW'(1) : '0;
      s1 <= cap_in; s2 <= s1; s3 <= s2;
      pin <= pin_n;
    end
  end

  for (genvar n = 0; n < 4; n++) begin : g_reg
    logic [W-1:0] q, src;
    logic reload;
    if (n < 2) begin : g_main
      assign reload = bufen[n] && !is_cap[n] && cmp_clr;
      assign src    = gr[n+2];
    end else begin : g_buf
      assign reload = bufen[n-2] && is_cap[n-2] && capev[n-2];
      assign src    = gr[n-2];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   q <= '1;
      else if (bus_wr && bus_addr == A_GR + 4'(n))  q <= bus_wdata;
      else if (capev[n])                            q <= cnt;
      else if (reload)                              q <= src;
    end
    assign gr[n] = q;
  end

  always_comb begin
    pin_n = pin;
    for (int n = 0; n < 4; n++) begin
      logic [1:0] t;
      t = pwm ? 2'(n & 2) : 2'(n);
      if (cmpev[n]) begin
        case (mode[3*n +: 2])
          2'b01:   pin_n[t] = 1'b0;
          2'b10:   pin_n[t] = 1'b1;
          2'b11:   pin_n[t] = ~pin_n[t];
          default: ;
        endcase
      end
    end
  end

  assign cmp_out = pwm ? {1'b0, pin[2], 1'b0, pin[0]} : pin;
  assign irq     = flags & ien;

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = W'(ctrl);
      A_MODE:  bus_rdata = W'(mode);
      A_IEN:   bus_rdata = W'(ien);
      A_FLAG:  bus_rdata = W'(flags);
      A_CNT:   bus_rdata = cnt;
      4'd5:    bus_rdata = gr[0];
      4'd6:    bus_rdata = gr[1];
      4'd7:    bus_rdata = gr[2];
      4'd8:    bus_rdata = gr[3];
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cctimer_chk.sv
module cctimer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_wr,
  input logic [3:0]   bus_addr,
  input logic [W-1:0] cnt,
  input logic         tick,
  input logic         clr,
  input logic [4:0]   flags,
  input logic [3:0]   capev,
  input logic [W-1:0] gr_a,
  input logic [W-1:0] gr_c,
  input logic         buf_ac
);
  wire wr_cnt  = bus_wr && bus_addr == 4'd4;
  wire wr_flag = bus_wr && bus_addr == 4'd3;
  wire wr_ac   = bus_wr && (bus_addr == 4'd5 || bus_addr == 4'd7);

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr && !wr_cnt) |=> $stable(cnt));

  // R5
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !wr_cnt) |=> (cnt == '0));

  // R6
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && !wr_cnt && cnt == '1) |=> flags[4]);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flag |=> ((flags & $past(flags)) == $past(flags)));

  // R4
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capev[0] && !(bus_wr && bus_addr == 4'd5)) |=> (gr_a == $past(cnt)));

  // R8
  cap_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_ac && capev[0] && !wr_ac) |=> (gr_c == $past(gr_a)));
endmodule

bind cctimer cctimer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .cnt(cnt), .tick(tick), .clr(clr), .flags(flags), .capev(capev),
  .gr_a(gr[0]), .gr_c(gr[2]), .buf_ac(ctrl[8])
);

// File: tb/sim_cctimer.sv
module sim_cctimer;
  logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [3:0]  cap_in = '0, cmp_out;
  logic [4:0]  irq;

  always #4 clk = ~clk;

  cctimer u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
    .cmp_out(cmp_out), .irq(irq));

  typedef struct {
    int          kind;
    logic [3:0]  addr;
    logic [15:0] exp;
    logic [15:0] mask;
    string       tag;
  } item_t;

  item_t sb[$];
  int checks = 0, fails = 0;
  bit done = 0;

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it  = sb.pop_front();
      act = (it.kind == 0) ? bus_rdata : (it.kind == 1) ? {12'b0, cmp_out} : {11'b0, irq};
      act = act & it.mask;
      checks++;
      if (act !== (it.exp & it.mask)) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp & it.mask);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic chk(input int kind, input logic [3:0] a, input logic [15:0] e,
                     input logic [15:0] m, input string tag);
    item_t it;
    @(posedge clk); #1;
    bus_addr = a;
    it.kind = kind; it.addr = a; it.exp = e; it.mask = m; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic pin(input int i, input logic v);
    @(posedge clk); #1;
    cap_in[i] = v;
    repeat (5) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    chk(0, 0, 16'h0000, 16'hFFFF, "R1 ctrl");
    chk(0, 4, 16'h0000, 16'hFFFF, "R1 count");
    chk(0, 5, 16'hFFFF, 16'hFFFF, "R1 reg A");
    chk(0, 3, 16'h0000, 16'hFFFF, "R1 flags");
    chk(1, 0, 16'h0000, 16'h000F, "R1 cmp_out");
    chk(2, 0, 16'h0000, 16'h001F, "R1 irq");

    wr(4, 16'h1234); chk(0, 4, 16'h1234, 16'hFFFF, "R11 count");
    wr(6, 16'h55AA); chk(0, 6, 16'h55AA, 16'hFFFF, "R11 reg B");

    wr(4, 16'h0000); wr(0, 16'h0042);
    repeat (38) @(posedge clk);
    wr(0, 16'h0002);
    chk(0, 4, 16'd10, 16'hFFFF, "R2 div4");
    repeat (10) @(posedge clk);
    chk(0, 4, 16'd10, 16'hFFFF, "R2 hold");
    wr(4, 16'h0000); wr(0, 16'h0040);
    repeat (38) @(posedge clk);
    wr(0, 16'h0000);
    chk(0, 4, 16'd40, 16'hFFFF, "R2 div1");

    wr(4, 16'h0000); wr(5, 16'd5); wr(6, 16'd3); wr(1, 16'h001A);
    wr(0, 16'h0040);
    repeat (38) @(posedge clk);
    wr(0, 16'h0000);
    chk(1, 0, 16'h0003, 16'h0003, "R3 drive1 and toggle");
    chk(0, 3, 16'h0003, 16'hFFFF, "R7 match flags");
    wr(2, 16'h0001);
    chk(2, 0, 16'h0001, 16'h001F, "R7 irq enable");
    wr(3, 16'h001E);
    chk(0, 3, 16'h0002, 16'hFFFF, "R7 write-zero clear");
    chk(2, 0, 16'h0000, 16'h001F, "R7 irq after clear");
    wr(1, 16'h0019); wr(4, 16'h0000); wr(0, 16'h0040);
    repeat (38) @(posedge clk);
    wr(0, 16'h0000);
    chk(1, 0, 16'h0000, 16'h0003, "R3 drive0 and toggle back");

    wr(3, 16'h0000); wr(1, 16'h0000); wr(0, 16'h0108);
    wr(4, 16'h0000); wr(5, 16'd9); wr(7, 16'd4);
    wr(0, 16'h0148);
    repeat (40) @(posedge clk);
    wr(0, 16'h0108);
    chk(0, 4, 16'd2, 16'hFFFF, "R5 clear on match A");
    chk(0, 5, 16'd4, 16'hFFFF, "R9 reload A from C");

    wr(0, 16'h0000); wr(4, 16'hFFFC); wr(3, 16'h0000); wr(2, 16'h0010);
    wr(0, 16'h0040);
    repeat (38) @(posedge clk);
    wr(0, 16'h0000);
    chk(0, 4, 16'h0024, 16'hFFFF, "R6 wrap");
    chk(0, 3, 16'h0010, 16'h0010, "R6 overflow flag");
    chk(2, 0, 16'h0010, 16'h0010, "R7 overflow irq");

    wr(1, 16'h0E35);
    wr(4, 16'h0100); pin(0, 1'b1);
    chk(0, 5, 16'h0100, 16'hFFFF, "R4 rising capture A");
    wr(4, 16'h0200); pin(1, 1'b1);
    chk(0, 6, 16'd3, 16'hFFFF, "R4 rising ignored on B");
    pin(1, 1'b0);
    chk(0, 6, 16'h0200, 16'hFFFF, "R4 falling capture B");
    wr(4, 16'h0300); pin(3, 1'b1);
    chk(0, 8, 16'h0300, 16'hFFFF, "R4 both edges D rise");
    wr(4, 16'h0301); pin(3, 1'b0);
    chk(0, 8, 16'h0301, 16'hFFFF, "R4 both edges D fall");

    wr(0, 16'h0100); pin(0, 1'b0);
    wr(4, 16'h0400); pin(0, 1'b1);
    chk(0, 5, 16'h0400, 16'hFFFF, "R8 new value in A");
    chk(0, 7, 16'h0100, 16'hFFFF, "R8 old A pushed to C");

    wr(0, 16'h0108); wr(4, 16'h0500);
    pin(0, 1'b0); pin(0, 1'b1);
    chk(0, 4, 16'h0000, 16'hFFFF, "R5 clear on capture A");
    chk(0, 7, 16'h0400, 16'hFFFF, "R8 second push");

    wr(0, 16'h0000); wr(1, 16'h000A);
    wr(5, 16'd2); wr(6, 16'd6); wr(4, 16'h0000);
    wr(0, 16'h00D0);
    repeat (43) @(posedge clk);
    wr(0, 16'h0090);
    chk(1, 0, 16'h0001, 16'h000F, "R10 pwm pins");
    chk(0, 4, 16'd3, 16'hFFFF, "R10 pwm period");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule